// File: doc/BRIEF.md
# Zoned Bandwidth Monitor

This block measures bus traffic over fixed sampling windows. Each valid byte beat adds its byte count to a saturating accumulator. When a window of programmed length closes, the total is converted to 64 KiB units. Three thresholds then place the window into one of four zones: idle, low, middle and heavy.

A programmable action map tells the block what each zone does to four 8-bit hit counters. A zone can increment some counters and clear others. When an incremented counter reaches its programmed repeat count, a sticky zone status bit is set. A masked level interrupt reports that status. For each zone the block also keeps the largest window it has seen, as units minus one.

Control runs through a small FSM with three states:
- **ST_OFF**: monitor stopped, accumulator and timer held at zero.
- **ST_RUN**: accumulating.
- **ST_EVAL**: the one cycle in which the captured window is applied to the counters.

The FSM has four transitions:
- **start**: ST_OFF to ST_RUN, when monitoring is enabled.
- **close**: ST_RUN or ST_EVAL to ST_EVAL, when the window timer expires.
- **continue**: back to ST_RUN, while monitoring stays enabled.
- **stop**: to ST_OFF, when monitoring is disabled and no window closes.

A new window starts in the cycle right after the previous one closes, so no beat is lost.

Top module: `zbw_monitor`

## Requirements
- R1: After reset every readable register reads 0 and `irq` is 0.
- R2: While monitoring is on (0x2A0 bit 0), a window closes after the number of clock cycles held in 0x2A8 bits [19:0]. Valid beats sampled in those cycles are summed. The window value is floor(bytes / 65536). A length of 0 closes no window.
- R3: The zone depends on the units value. Zone 3 applies if units > high (0x2AC). Otherwise zone 2 applies if units > medium (0x2B0). Otherwise zone 1 applies if units >= low (0x2B4). Otherwise the zone is 0.
- R4: On evaluation of zone z, byte z of 0x2B8 (bits [8z+7:8z]) holds one 2-bit slot per target counter t. Bit 2t+1 increments counter t, and bit 2t clears it. A clear beats an increment in the same byte. Counters change only on evaluation or a clear.
- R5: Writing 1 to 0x2A4 bit 0 zeroes all hit counters, all maxima, the accumulator and the window timer. If this write lands on an evaluation cycle, the clear wins.
- R6: On evaluation of zone z, the value units-1 (0 if units is 0) replaces the maximum of zone z when it is larger. Maxima read at 0x2E0 + 4·z.
- R7: Repeat counts sit in 0x2BC, byte t for counter t. An increment that leaves counter t at or above its repeat count sets status bit 4+t of 0x100. A count of 0xFF never sets it. Status bits latch whatever their enable is. Writing 1 to a bit of 0x108 clears that bit.
- R8: `irq` equals 0x00C bit 0 AND any status bit whose enable bit in 0x10C (bits [7:4]) is 1. Bit 0 of 0x000 is a sticky copy of that pending condition, and writing 1 to 0x008 bit 0 clears it.
- R9: The byte accumulator saturates at all ones instead of wrapping.
- R10: While monitoring is off, beats are ignored and no evaluation takes place.
- R11: Hit counters read packed at 0x2D8, counter z in bits [8z+7:8z].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the window tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| beat_valid | input | 1 | Byte beat valid |
| beat_bytes | input | BEAT_W | Bytes carried by the beat |
| irq | output | 1 | Level interrupt |

## Verification
The counter-clear write and the window evaluation can both fall on the same clock edge. The evaluation wants to increment a hit counter, while the clear wants every counter at zero. The bench provokes this by enabling the monitor with no traffic and counting cycles from the enable write. It places the clear write exactly on the edge that applies the closing window's zone-0 action. It judges the result through the counter and maximum registers: both must read zero, whereas the same window without the clear leaves counter 0 at 1.

// File: rtl/zbw_pkg.sv
package zbw_pkg;
    localparam int NZONES = 4;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_EVAL = 2'd2
    } mon_state_e;

    localparam logic [11:0] A_GSTAT = 12'h000;
    localparam logic [11:0] A_GCLR  = 12'h008;
    localparam logic [11:0] A_GEN   = 12'h00C;
    localparam logic [11:0] A_ZSTAT = 12'h100;
    localparam logic [11:0] A_ZCLR  = 12'h108;
    localparam logic [11:0] A_ZEN   = 12'h10C;
    localparam logic [11:0] A_MON   = 12'h2A0;
    localparam logic [11:0] A_CCLR  = 12'h2A4;
    localparam logic [11:0] A_WIN   = 12'h2A8;
    localparam logic [11:0] A_THI   = 12'h2AC;
    localparam logic [11:0] A_TMED  = 12'h2B0;
    localparam logic [11:0] A_TLO   = 12'h2B4;
    localparam logic [11:0] A_ACT   = 12'h2B8;
    localparam logic [11:0] A_RPT   = 12'h2BC;
    localparam logic [11:0] A_CNT   = 12'h2D8;
    localparam logic [7:0]  A_MAXHI = 8'h2E;
endpackage

// File: rtl/zbw_window.sv
module zbw_window
    import zbw_pkg::*;
#(
    parameter int WIN_W      = 20,
    parameter int BEAT_W     = 20,
    parameter int ACC_W      = 32,
    parameter int UNIT_SHIFT = 16,
    localparam int UNIT_W    = ACC_W - UNIT_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mon_en,
    input  logic [WIN_W-1:0]  win_len,
    input  logic              cnt_clr,
    input  logic              beat_valid,
    input  logic [BEAT_W-1:0] beat_bytes,
    output logic              eval_go,
    output logic [UNIT_W-1:0] snap_units
);
    mon_state_e state_q, state_d;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sat;
    logic [ACC_W:0]   sum_w;
    logic [ACC_W:0]   beat_x;
    logic [WIN_W-1:0] timer_q;
    logic             win_end;

    // saturating accumulation of this cycle's beat
    always_comb begin
        beat_x  = beat_valid ? {{(ACC_W + 1 - BEAT_W){1'b0}}, beat_bytes} : '0;
        sum_w   = {1'b0, acc_q} + beat_x;
        acc_sat = sum_w[ACC_W] ? '1 : sum_w[ACC_W-1:0];
        win_end = (state_q != ST_OFF) && (win_len != '0) &&
                  (timer_q == win_len - WIN_W'(1));
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:          state_d = mon_en ? ST_RUN : ST_OFF;
            ST_RUN, ST_EVAL: state_d = win_end ? ST_EVAL : (mon_en ? ST_RUN : ST_OFF);
            default:         state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // accumulator and window timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            timer_q <= '0;
        end else if (cnt_clr || state_q == ST_OFF || win_end) begin
            acc_q   <= '0;
            timer_q <= '0;
        end else begin
            acc_q   <= acc_sat;
            timer_q <= timer_q + WIN_W'(1);
        end
    end

    // window capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       snap_units <= '0;
        else if (win_end) snap_units <= acc_sat[ACC_W-1:UNIT_SHIFT];
    end

    // outputs
    always_comb begin
        eval_go = (state_q == ST_EVAL);
    end
endmodule

// File: rtl/zbw_zone_ctrl.sv
module zbw_zone_ctrl
    import zbw_pkg::*;
#(
    parameter int UNIT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     eval_go,
    input  logic [UNIT_W-1:0]        units,
    input  logic [31:0]              thr_lo,
    input  logic [31:0]              thr_med,
    input  logic [31:0]              thr_hi,
    input  logic [31:0]              act_map,
    input  logic [31:0]              rpt_cnt,
    input  logic                     cnt_clr,
    output logic [31:0]              hit_cnt,
    output logic [NZONES*UNIT_W-1:0] zone_max,
    output logic [NZONES-1:0]        hit_set
);
    logic [31:0]       ux;
    logic [1:0]        zone_w;
    logic [7:0]        act_byte;
    logic [UNIT_W-1:0] m1;

    always_comb begin
        ux = {{(32 - UNIT_W){1'b0}}, units};
        if (ux > thr_hi)       zone_w = 2'd3;
        else if (ux > thr_med) zone_w = 2'd2;
        else if (ux >= thr_lo) zone_w = 2'd1;
        else                   zone_w = 2'd0;
        act_byte = act_map[{zone_w, 3'b000} +: 8];
        m1 = (units == '0) ? '0 : units - UNIT_W'(1);
    end

    for (genvar t = 0; t < NZONES; t++) begin : g_zone
        logic [7:0]        cnt_q;
        logic [7:0]        cnt_inc;
        logic [7:0]        rpt_t;
        logic [UNIT_W-1:0] max_q;
        logic              inc_t;
        logic              clr_t;

        always_comb begin
            inc_t   = eval_go & act_byte[2*t+1];
            clr_t   = eval_go & act_byte[2*t];
            cnt_inc = (cnt_q == 8'hFF) ? cnt_q : cnt_q + 8'd1;
            rpt_t   = rpt_cnt[8*t +: 8];
            hit_set[t] = inc_t & ~clr_t & ~cnt_clr & (rpt_t != 8'hFF) & (cnt_inc >= rpt_t);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt_q <= '0;
            else if (cnt_clr || clr_t) cnt_q <= '0;
            else if (inc_t)            cnt_q <= cnt_inc;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       max_q <= '0;
            else if (cnt_clr) max_q <= '0;
            else if (eval_go && int'(zone_w) == t && m1 > max_q) max_q <= m1;
        end

        assign hit_cnt[8*t +: 8]            = cnt_q;
        assign zone_max[t*UNIT_W +: UNIT_W] = max_q;
    end
endmodule

// File: rtl/zbw_monitor.sv
module zbw_monitor
    import zbw_pkg::*;
#(
    parameter int WIN_W      = 20,
    parameter int BEAT_W     = 20,
    parameter int ACC_W      = 32,
    parameter int UNIT_SHIFT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              beat_valid,
    input  logic [BEAT_W-1:0] beat_bytes,
    output logic              irq
);
    localparam int UNIT_W = ACC_W - UNIT_SHIFT;

    logic              glb_en_q, gstat_q, mon_en_q;
    logic [3:0]        zstat_q, zen_q;
    logic [WIN_W-1:0]  win_len_q;
    logic [31:0]       thr_hi_q, thr_med_q, thr_lo_q, act_q, rpt_q;

    logic              cnt_clr, zclr_wr, gclr_wr, pend, win_zero, eval_go;
    logic [3:0]        zclr_mask;
    logic [UNIT_W-1:0] snap_units;
    logic [31:0]       hit_cnt;
    logic [NZONES*UNIT_W-1:0] zone_max;
    logic [NZONES-1:0] hit_set;

    always_comb begin
        cnt_clr   = reg_wr && reg_addr == A_CCLR && reg_wdata[0];
        zclr_wr   = reg_wr && reg_addr == A_ZCLR;
        gclr_wr   = reg_wr && reg_addr == A_GCLR && reg_wdata[0];
        zclr_mask = zclr_wr ? reg_wdata[7:4] : 4'b0;
        pend      = |(zstat_q & zen_q);
        win_zero  = (win_len_q == '0);
    end

    zbw_window #(
        .WIN_W(WIN_W), .BEAT_W(BEAT_W), .ACC_W(ACC_W), .UNIT_SHIFT(UNIT_SHIFT)
    ) win_i (
        .clk(clk), .rst_n(rst_n), .mon_en(mon_en_q), .win_len(win_len_q),
        .cnt_clr(cnt_clr), .beat_valid(beat_valid), .beat_bytes(beat_bytes),
        .eval_go(eval_go), .snap_units(snap_units)
    );

    zbw_zone_ctrl #(.UNIT_W(UNIT_W)) zone_i (
        .clk(clk), .rst_n(rst_n), .eval_go(eval_go), .units(snap_units),
        .thr_lo(thr_lo_q), .thr_med(thr_med_q), .thr_hi(thr_hi_q),
        .act_map(act_q), .rpt_cnt(rpt_q), .cnt_clr(cnt_clr),
        .hit_cnt(hit_cnt), .zone_max(zone_max), .hit_set(hit_set)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glb_en_q  <= 1'b0;
            gstat_q   <= 1'b0;
            mon_en_q  <= 1'b0;
            zstat_q   <= '0;
            zen_q     <= '0;
            win_len_q <= '0;
            thr_hi_q  <= '0;
            thr_med_q <= '0;
            thr_lo_q  <= '0;
            act_q     <= '0;
            rpt_q     <= '0;
        end else begin
            if (reg_wr) begin
                if (reg_addr == A_GEN)  glb_en_q  <= reg_wdata[0];
                if (reg_addr == A_ZEN)  zen_q     <= reg_wdata[7:4];
                if (reg_addr == A_MON)  mon_en_q  <= reg_wdata[0];
                if (reg_addr == A_WIN)  win_len_q <= reg_wdata[WIN_W-1:0];
                if (reg_addr == A_THI)  thr_hi_q  <= reg_wdata;
                if (reg_addr == A_TMED) thr_med_q <= reg_wdata;
                if (reg_addr == A_TLO)  thr_lo_q  <= reg_wdata;
                if (reg_addr == A_ACT)  act_q     <= reg_wdata;
                if (reg_addr == A_RPT)  rpt_q     <= reg_wdata;
            end
            zstat_q <= (zstat_q & ~zclr_mask) | hit_set;
            gstat_q <= (gstat_q & ~gclr_wr) | pend;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[11:4] == A_MAXHI && reg_addr[1:0] == 2'b00) begin
            reg_rdata = {{(32 - UNIT_W){1'b0}}, zone_max[reg_addr[3:2]*UNIT_W +: UNIT_W]};
        end else begin
            case (reg_addr)
                A_GSTAT: reg_rdata = {31'b0, gstat_q};
                A_GEN:   reg_rdata = {31'b0, glb_en_q};
                A_ZSTAT: reg_rdata = {24'b0, zstat_q, 4'b0};
                A_ZEN:   reg_rdata = {24'b0, zen_q, 4'b0};
                A_MON:   reg_rdata = {31'b0, mon_en_q};
                A_WIN:   reg_rdata = {{(32 - WIN_W){1'b0}}, win_len_q};
                A_THI:   reg_rdata = thr_hi_q;
                A_TMED:  reg_rdata = thr_med_q;
                A_TLO:   reg_rdata = thr_lo_q;
                A_ACT:   reg_rdata = act_q;
                A_RPT:   reg_rdata = rpt_q;
                A_CNT:   reg_rdata = hit_cnt;
                default: reg_rdata = '0;
            endcase
        end
    end

    assign irq = glb_en_q & pend;
endmodule

// File: rtl/zbw_monitor_chk.sv
module zbw_monitor_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        irq,
    input logic        glb_en,
    input logic [3:0]  zstat,
    input logic [3:0]  zen,
    input logic [31:0] hit_cnt,
    input logic        cnt_clr,
    input logic        eval_go,
    input logic        win_zero,
    input logic        zclr_wr
);
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> glb_en); // R8
    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ((zstat & zen) == 4'b0) |-> !irq); // R8
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (hit_cnt == 32'b0)); // R5
    AST_COUNT_ON_EVAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!eval_go && !cnt_clr) |=> $stable(hit_cnt)); // R4
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !zclr_wr |=> ((zstat & $past(zstat)) == $past(zstat))); // R7
    AST_ZERO_LEN_NO_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (win_zero && !eval_go) |=> !eval_go); // R2
endmodule

bind zbw_monitor zbw_monitor_chk chk_i (
    .clk(clk), .rst_n(rst_n), .irq(irq), .glb_en(glb_en_q),
    .zstat(zstat_q), .zen(zen_q), .hit_cnt(hit_cnt), .cnt_clr(cnt_clr),
    .eval_go(eval_go), .win_zero(win_zero), .zclr_wr(zclr_wr)
);

// File: tb/zbw_monitor_tb.sv
module zbw_monitor_tb_top;
    localparam int W = 20;
    localparam logic [31:0] ACT_ID = 32'h8020_0802;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        beat_valid = 1'b0;
    logic [19:0] beat_bytes = '0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    zbw_monitor #(.ACC_W(24)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .beat_valid(beat_valid),
        .beat_bytes(beat_bytes), .irq(irq)
    );

    // vector table: bytes per beat, beats, expected zone, expected max
    localparam int VB [0:7] = '{0, 131071, 131072, 65536, 196608, 589824, 655360, 983040};
    localparam int VN [0:7] = '{1, 1, 1, 5, 2, 1, 1, 2};
    localparam int VZ [0:7] = '{0, 0, 1, 1, 2, 2, 3, 3};
    localparam int VM [0:7] = '{0, 0, 1, 4, 5, 8, 9, 29};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic run_window(input int bytes, input int n);
        wr(12'h2A0, 32'h1);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            beat_valid = 1'b1;
            beat_bytes = 20'(bytes);
            @(negedge clk);
        end
        beat_valid = 1'b0;
        repeat (W + 4 - n) @(negedge clk);
        wr(12'h2A0, 32'h0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(12'h2D8, d); check("R1 counters", d, 0);
        rd(12'h100, d); check("R1 zone status", d, 0);
        rd(12'h000, d); check("R1 global status", d, 0);
        rd(12'h2A8, d); check("R1 window length", d, 0);
        rd(12'h2E4, d); check("R1 max", d, 0);
        check("R1 irq", {31'b0, irq}, 0);

        wr(12'h2A8, W);
        wr(12'h2B4, 2);
        wr(12'h2B0, 5);
        wr(12'h2AC, 9);
        wr(12'h2B8, ACT_ID);
        wr(12'h2BC, 32'hFFFF_FFFF);

        // R2 R3 R6 R11: table walk
        for (int v = 0; v < 8; v++) begin
            wr(12'h2A4, 1);
            run_window(VB[v], VN[v]);
            rd(12'h2D8, d);
            check($sformatf("R3 zone vec%0d", v), d, 32'h1 << (8 * VZ[v]));
            rd(12'(12'h2E0 + 4 * VZ[v]), d);
            check($sformatf("R6 max vec%0d", v), d, VM[v]);
        end

        // R5 clear zeroes maxima (zone 3 held 29)
        wr(12'h2A4, 1);
        rd(12'h2EC, d); check("R5 clear max", d, 0);

        // R6 highest kept, R11 packing
        run_window(65536, 5);
        run_window(131072, 1);
        rd(12'h2E4, d); check("R6 highest kept", d, 4);
        rd(12'h2D8, d); check("R11 counter packing", d, 32'h0000_0200);

        // R4 zone 3 increments itself and clears counters 0 and 1
        wr(12'h2B8, 32'h8520_0802);
        run_window(655360, 1);
        rd(12'h2D8, d); check("R4 action clears", d, 32'h0100_0000);
        wr(12'h2B8, ACT_ID);

        // R5 clear on the evaluation edge (empty window -> zone 0)
        wr(12'h2A4, 1);
        wr(12'h2A0, 1);
        repeat (W) @(negedge clk);
        wr(12'h2A4, 1);
        repeat (5) @(negedge clk);
        wr(12'h2A0, 0);
        repeat (3) @(negedge clk);
        rd(12'h2D8, d); check("R5 clear beats eval", d, 0);

        // R2 zero length evaluates nothing
        wr(12'h2A8, 0);
        run_window(655360, 1);
        rd(12'h2D8, d); check("R2 zero length", d, 0);
        wr(12'h2A8, W);

        // R10 beats while off are ignored
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); beat_valid = 1'b1; beat_bytes = 20'd655360;
        end
        @(negedge clk); beat_valid = 1'b0;
        rd(12'h2D8, d); check("R10 off ignores", d, 0);

        // R7 R8 repeat count and interrupt
        wr(12'h2BC, 32'hFFFF_02FF);
        wr(12'h10C, 32'h20);
        wr(12'h00C, 1);
        wr(12'h108, 32'hF0);
        wr(12'h008, 1);
        run_window(131072, 1);
        rd(12'h100, d); check("R7 below repeat", d, 0);
        check("R8 irq idle", {31'b0, irq}, 0);
        run_window(131072, 1);
        rd(12'h100, d); check("R7 repeat reached", d, 32'h20);
        check("R8 irq raised", {31'b0, irq}, 1);
        rd(12'h000, d); check("R8 global status", d, 1);
        wr(12'h108, 32'h20);
        rd(12'h100, d); check("R7 status clear", d, 0);
        check("R8 irq dropped", {31'b0, irq}, 0);
        wr(12'h008, 1);
        rd(12'h000, d); check("R8 global clear", d, 0);
        wr(12'h10C, 0);
        run_window(131072, 1);
        rd(12'h100, d); check("R7 latch when masked", d, 32'h20);
        check("R8 masked irq", {31'b0, irq}, 0);
        wr(12'h10C, 32'h20);
        check("R8 unmask irq", {31'b0, irq}, 1);
        wr(12'h00C, 0);
        check("R8 global mask", {31'b0, irq}, 0);

        // R9 accumulator saturation: 17 beats exceed 2^24 bytes
        wr(12'h2BC, 32'hFFFF_FFFF);
        wr(12'h2A4, 1);
        run_window(1048575, 17);
        rd(12'h2EC, d); check("R9 saturate max", d, 254);
        rd(12'h2D8, d); check("R9 saturate zone", d, 32'h0100_0000);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule